// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a small field-configurable logic device. Eight data inputs and eight pin feedback lines form sixteen array lines. Each line is offered to a programmable AND plane in true and complemented form. The plane has 64 product terms, and every term can connect to any of the 32 literal columns. The terms fall into eight groups of eight, one group per output cell. Each cell ORs its group, applies its own polarity bit, and drives its pin as a registered output, a combinational output or an input. The behaviour depends on a two-bit global mode and the cell's own direction bit.

The whole configuration arrives as one static vector, `cfg`. Pins are not modelled as bidirectional pads. Each cell presents a value on `io_out` and an enable on `io_oe`. Whatever the surrounding level resolves onto the pad comes back on `io_in`, which is where every combinational pin feedback is taken. In registered mode, `clk` acts as the shared register clock and `pin11` as the shared active-low enable. In the two combinational modes, `pin1_d` and `pin11` are plain data inputs that enter the array through the feedback columns of the two outermost cells.

Top module: `pal_array`

## Requirements
- R1: Global mode is `{cfg[2065], cfg[2064]}`. When bit 2064 is 0 the mode is registered. The value 2'b01 selects simple mode and 2'b11 selects complex mode. The mode applies to all eight cells at once.
- R2: Term t (0..63) uses fuses `cfg[t*32 +: 32]`, where a 1 means connected. Column 2k carries line k true and column 2k+1 carries line k complemented. Lines 0..7 are `din[0..7]` and lines 8..15 are the feedback columns of cells 0..7. A term is the AND of its connected literals. A term with no connection is 0, and a term holding both forms of one line is 0.
- R3: Cell m owns terms 8m..8m+7, and term 8m is its first term. Its polarity bit is `cfg[2048+m]` and its direction bit is `cfg[2056+m]`. Every cell's result is its OR-sum XOR its polarity bit, in every mode.
- R4: In registered mode, a cell with direction 0 loads polarity XOR OR(all 8 terms) on each rising `clk`. `io_out[m]` shows the register and `io_oe[m]` equals `!pin11`. Its feedback column carries the register.
- R5: In registered mode, a cell with direction 1 is combinational. Its first term is the enable and terms 2..8 form the sum. Its feedback column carries `io_in[m]`. `pin1_d` and `pin11` never reach the array in this mode.
- R6: In complex mode, a cell with direction 0 uses its first term as the enable and the other seven as the sum. A cell with direction 1 has its enable held at 0. Feedback column 0 carries `pin1_d`, column 7 carries `pin11`, and columns 1..6 carry `io_in[1..6]`.
- R7: In simple mode, a cell with direction 0 is always enabled and sums all 8 terms. A cell with direction 1 has its enable held at 0. Cells 3 and 4 are always enabled outputs. Feedback column 0 carries `pin1_d` and column 7 carries `pin11`. Columns 1..3 carry `io_in[0..2]` and columns 4..6 carry `io_in[5..7]`, so pins of cells 3 and 4 never feed back.
- R8: A low `rst_n` clears all eight registers asynchronously. In registered mode, outputs of direction-0 cells then read 0.
- R9: A high `preload_en` at a rising `clk` loads `preload_val` into the registers in place of the array result.
- R10: Combinational outputs and enables follow input changes within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock (shared clock pin in registered mode) |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| cfg | input | 2066 | Fuse plane, polarity, direction and global mode bits |
| din | input | 8 | Dedicated data inputs, array lines 0..7 |
| pin1_d | input | 1 | Clock-pin data value, used as an input in combinational modes |
| pin11 | input | 1 | Enable pin: active-low enable (registered) or data input |
| io_in | input | 8 | Resolved pad value of each cell pin |
| preload_en | input | 1 | Force registers from preload_val at the next edge |
| preload_val | input | 8 | Register preload value |
| io_out | output | 8 | Value each cell presents to its pin |
| io_oe | output | 8 | Drive enable of each cell pin |

## Verification
Combinational cells settle in the same cycle as the input that moves them. The bench therefore samples one time unit after it drives, well before the next rising edge. Registered cells change only at the rising edge after their inputs were presented. The bench's reference model commits its next register state just past that edge, so a preload or array result first shows at the following sample point. Random sparse fuse maps run in all three modes and are compared on every cycle. Directed cases pin down the empty and self-contradicting terms, polarity, pin-1/pin-11 routing and the inner-cell rule.

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN   = 8,
  parameter int N_CELL = 8,
  parameter int PT_PER = 8,
  localparam int N_LINE = N_IN + N_CELL,
  localparam int N_COL  = 2 * N_LINE,
  localparam int N_PT   = N_CELL * PT_PER,
  localparam int FUSE_W = N_PT * N_COL,
  localparam int CFG_W  = FUSE_W + 2 * N_CELL + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [N_IN-1:0]   din,
  input  logic              pin1_d,
  input  logic              pin11,
  input  logic [N_CELL-1:0] io_in,
  input  logic              preload_en,
  input  logic [N_CELL-1:0] preload_val,
  output logic [N_CELL-1:0] io_out,
  output logic [N_CELL-1:0] io_oe
);

  localparam logic [N_CELL-1:0] INNER_MASK = N_CELL'(3) << (N_CELL/2 - 1);

  logic [N_CELL-1:0] pol, dir, q, d, fb;
  logic [N_LINE-1:0] line;
  logic [N_COL-1:0]  lits;
  logic [N_PT-1:0]   pt;
  logic is_reg, is_simple, is_cplx;

  assign pol       = cfg[FUSE_W +: N_CELL];
  assign dir       = cfg[FUSE_W + N_CELL +: N_CELL];
  assign is_reg    = !cfg[CFG_W-2];
  assign is_simple = cfg[CFG_W-2] & !cfg[CFG_W-1];
  assign is_cplx   = cfg[CFG_W-2] & cfg[CFG_W-1];

  assign line = {fb, din};

  for (genvar k = 0; k < N_LINE; k++) begin : g_lit
    assign lits[2*k]   = line[k];
    assign lits[2*k+1] = ~line[k];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    wire [N_COL-1:0] fz = cfg[t*N_COL +: N_COL];
    assign pt[t] = (|fz) & (&(lits | ~fz));
  end

  for (genvar m = 0; m < N_CELL; m++) begin : g_cell
    localparam bit INNER = (m == N_CELL/2 - 1) || (m == N_CELL/2);
    wire [PT_PER-1:0] grp = pt[m*PT_PER +: PT_PER];
    wire sum_all  = |grp;
    wire sum_rest = |grp[PT_PER-1:1];
    wire reg_cell = is_reg & !dir[m];
    wire pt_oe    = is_cplx | (is_reg & dir[m]);
    wire comb_val = pol[m] ^ (pt_oe ? sum_rest : sum_all);
    logic fb_c, fb_s;

    if (m == 0) begin : g_edge
      assign fb_c = pin1_d;
      assign fb_s = pin1_d;
    end else if (m == N_CELL-1) begin : g_edge
      assign fb_c = pin11;
      assign fb_s = pin11;
    end else if (m < N_CELL/2) begin : g_edge
      assign fb_c = io_in[m];
      assign fb_s = io_in[m-1];
    end else begin : g_edge
      assign fb_c = io_in[m];
      assign fb_s = io_in[m+1];
    end

    assign d[m]      = pol[m] ^ sum_all;
    assign io_out[m] = reg_cell ? q[m] : comb_val;
    assign io_oe[m]  = reg_cell  ? !pin11 :
                       is_simple ? (INNER || !dir[m]) :
                       is_cplx   ? (!dir[m] & grp[0]) : grp[0];
    assign fb[m]     = is_reg  ? (dir[m] ? io_in[m] : q[m]) :
                       is_cplx ? fb_c : fb_s;

    AST_REG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      reg_cell |-> (io_out[m] == q[m]) && (io_oe[m] == !pin11)); // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (preload_en) q <= preload_val;
    else                 q <= d;
  end

  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> q == $past(preload_val)); // R9
  AST_ARRAY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_en |=> q == $past(d)); // R4
  AST_INNER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    is_simple |-> io_oe[N_CELL/2-1] && io_oe[N_CELL/2]); // R7
  AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (is_simple || is_cplx) |-> (io_oe & dir & ~INNER_MASK) == '0); // R6
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({is_reg, is_simple, is_cplx})); // R1

endmodule

// File: tb/pal_array_tb.sv
module pal_array_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic [2065:0] cfg = '0;
  logic [7:0] din = 0, pad = 0, pre_val = 0, io_out, io_oe, mq = 0;
  logic p1 = 0, p11 = 0, pre_en = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pal_array u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .din(din), .pin1_d(p1), .pin11(p11),
    .io_in(pad), .preload_en(pre_en), .preload_val(pre_val),
    .io_out(io_out), .io_oe(io_oe));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic eval(output logic [7:0] eo, output logic [7:0] eoe, output logic [7:0] nq);
    logic [7:0] fbv, d;
    logic [15:0] ln;
    logic [63:0] p;
    int md;
    md = !cfg[2064] ? 0 : (cfg[2065] ? 2 : 1);
    for (int m = 0; m < 8; m++) begin
      if (md == 0)      fbv[m] = cfg[2056+m] ? pad[m] : mq[m];
      else if (m == 0)  fbv[m] = p1;
      else if (m == 7)  fbv[m] = p11;
      else if (md == 2) fbv[m] = pad[m];
      else if (m <= 3)  fbv[m] = pad[m-1];
      else              fbv[m] = pad[m+1];
    end
    ln = {fbv, din};
    for (int t = 0; t < 64; t++) begin
      logic any, v;
      any = 0; v = 1;
      for (int c = 0; c < 32; c++)
        if (cfg[t*32+c]) begin
          any = 1;
          v = v & ((c % 2) ? ~ln[c/2] : ln[c/2]);
        end
      p[t] = any & v;
    end
    for (int m = 0; m < 8; m++) begin
      logic [7:0] g;
      logic pl, a;
      g = p[8*m +: 8]; pl = cfg[2048+m]; a = cfg[2056+m];
      d[m] = pl ^ (|g);
      if (md == 0 && !a)     begin eo[m] = mq[m]; eoe[m] = !p11; end
      else if (md == 0)      begin eo[m] = pl ^ (|g[7:1]); eoe[m] = g[0]; end
      else if (md == 2)      begin eo[m] = pl ^ (|g[7:1]); eoe[m] = !a & g[0]; end
      else                   begin eo[m] = pl ^ (|g); eoe[m] = (m == 3 || m == 4) || !a; end
    end
    nq = pre_en ? pre_val : d;
  endtask

  task automatic tick(string tag);
    logic [7:0] eo, eoe, nq;
    #1;
    eval(eo, eoe, nq);
    check(tag, {io_out, io_oe}, {eo, eoe});
    @(posedge clk);
    #1 mq = rst_n ? nq : 8'h00;
    @(negedge clk);
  endtask

  task automatic rand_fuses();
    cfg[2047:0] = '0;
    for (int t = 0; t < 64; t++)
      if ($urandom % 4 != 0)
        for (int j = 0; j <= int'($urandom % 2); j++) cfg[t*32 + ($urandom % 32)] = 1'b1;
    cfg[2063:2048] = 16'($urandom);
  endtask

  task automatic run(string tag, int n, bit pre);
    for (int i = 0; i < n; i++) begin
      din = 8'($urandom); pad = 8'($urandom);
      p1 = 1'($urandom); p11 = 1'($urandom);
      pre_en = pre && ($urandom % 5 == 0); pre_val = 8'($urandom);
      tick(tag);
    end
    pre_en = 0;
  endtask

  task automatic set_mode(bit comb, bit cplx);
    cfg[2064] = comb; cfg[2065] = cplx;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1 check("R8 reset clear", {io_out, io_oe}, {8'h00, 8'hFF});
    tick("R8"); tick("R8");
    rst_n = 1;

    rand_fuses(); cfg[2063:2056] = 8'h00; set_mode(0, 0);
    run("R4 registered", 40, 0);

    pre_en = 1; pre_val = 8'hA5; p11 = 0;
    tick("R9");
    pre_en = 0;
    #1 check("R9 preload", {io_out, io_oe}, {8'hA5, 8'hFF});
    tick("R9");

    for (int r = 0; r < 3; r++) begin
      rand_fuses(); set_mode(0, 0);
      run("R5 registered mixed", 30, 1);
    end

    for (int r = 0; r < 3; r++) begin
      rand_fuses(); set_mode(1, 1);
      run("R6 complex", 30, 0);
    end

    for (int r = 0; r < 3; r++) begin
      rand_fuses(); set_mode(1, 0);
      run("R7 simple", 30, 0);
    end

    cfg = '0; set_mode(1, 0); cfg[2063:2056] = 8'hFF;
    tick("R7");
    #1 check("R7 inner cells always drive", {8'h00, io_oe}, {8'h00, 8'h18});

    cfg = '0; set_mode(1, 0);
    cfg[40*32 + 0] = 1; cfg[40*32 + 1] = 1;
    cfg[48*32 + 3] = 1;
    cfg[0*32 + 18] = 1;
    for (int v = 0; v < 2; v++) begin
      din = 8'(v * 3); pad = 8'(v);
      #1 check("R2 contradicting term", {15'h0, io_out[5]}, 16'h0);
      check("R2 complemented literal", {15'h0, io_out[6]}, {15'h0, ~din[1]});
      check("R10 simple feedback same cycle", {15'h0, io_out[0]}, {15'h0, pad[0]});
      tick("R2");
    end
    cfg[2048+5] = 1;
    #1 check("R3 polarity on empty sum", {15'h0, io_out[5]}, 16'h1);
    tick("R3");

    cfg = '0; set_mode(1, 1);
    cfg[8*32 + 0] = 1; cfg[9*32 + 16] = 1;
    cfg[16*32 + 0] = 1; cfg[17*32 + 30] = 1;
    din = 8'h01;
    for (int v = 0; v < 2; v++) begin
      p1 = v[0]; p11 = !v[0];
      #1 check("R6 pin1 data route", {14'h0, io_oe[1], io_out[1]}, {14'h0, 1'b1, v[0]});
      check("R6 pin11 data route", {14'h0, io_oe[2], io_out[2]}, {14'h0, 1'b1, !v[0]});
      tick("R6");
    end

    cfg = '0; cfg[8*32 + 16] = 1;
    for (int md = 0; md < 3; md++) begin
      set_mode(md != 0, md == 2);
      for (int v = 0; v < 2; v++) begin
        p11 = v[0]; p1 = 1;
        #1;
        if (md == 0) check("R1 registered oe follows pin11", {15'h0, io_oe[0]}, {15'h0, !v[0]});
        else if (md == 1) check("R1 simple always drives", {15'h0, io_oe[0]}, 16'h1);
        else check("R1 complex term enable", {15'h0, io_oe[0]}, 16'h0);
        tick("R1");
      end
    end
    set_mode(0, 0); cfg[2056+1] = 1; din = 0;
    p1 = 0; #1 check("R5 pin1 not in array", {15'h0, io_out[1]}, 16'h0);
    tick("R5");
    p1 = 1; #1 check("R5 pin1 not in array", {15'h0, io_out[1]}, 16'h0);
    tick("R5");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule